// File: doc/BRIEF.md
# Cascaded Converter Chain Readout Controller

This block is the host-side master for a string of serial sampling converters that share one convert line and one data clock. The converters are wired in a cascade: each one's serial output feeds the tag input of its neighbour, and the device nearest the host drives the host's serial input. On a start request the controller drives the convert line low for a fixed number of cycles. It then waits for the shared busy line to fall and rise again. During the following acquisition period it runs a gated data clock long enough to pull every device's result through the chain.

The converters are strapped for two's complement output. The serial stream is one 16-bit word per device, MSB first, with a single separator bit after every word except the last. The controller drops the separators. It can re-code each word to offset binary, and it presents the words one at a time with a valid strobe and the index of the device that produced them. Before it starts a conversion, the controller compares the length of the read it is about to perform against a programmable acquisition window. If the read does not fit, it refuses the request.

Top module: `chain_readout_ctrl`

## Requirements
- R1: An accepted start drives `conv_n` low for exactly CONV_CYC clock cycles (default 5), once per frame.
- R2: `dclk` stays low while `conv_n` is low and while `busy_i` is low. Clocks are issued only after `busy_i` has fallen and then returned high.
- R3: Each frame issues exactly 16 + 17*(N_DEV-1) rising `dclk` edges (50 for the default N_DEV of 3). Each high phase and each low phase lasts HALF_CYC clock cycles (default 2).
- R4: `sdata` is sampled on each falling `dclk` edge. Word bits arrive MSB first, and the first word received is reported with index 0 (the device nearest the host), in ascending order.
- R5: The bit that follows each of the first N_DEV-1 words is discarded whatever its level. A separator driven high does not alter any word.
- R6: With `offset_fmt`=0 the word is passed as received (two's complement). With `offset_fmt`=1 its MSB is inverted, so 0x7FFF becomes 0xFFFF and 0x8000 becomes 0x0000.
- R7: `word_valid` is high for one cycle per word with `word_idx` below N_DEV. `frame_done` pulses in the same cycle as the valid of the last word.
- R8: The read length is SETUP_CYC + 2*HALF_CYC*(16+17*(N_DEV-1)) cycles (203 by default). If it exceeds `acq_window` at start, `win_err` is set and no conversion begins. A window equal to the read length is accepted, and an accepted start clears `win_err`.
- R9: A start request while a frame is in progress is ignored.
- R10: In reset, and after it, `conv_n`=1, `dclk`=0, `word_valid`=0, `frame_done`=0 and `win_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one convert-and-read frame |
| offset_fmt | input | 1 | 1: output offset binary, 0: two's complement |
| acq_window | input | WIN_W | Acquisition window length in clock cycles |
| busy_i | input | 1 | Shared converter busy line, low while converting |
| sdata | input | 1 | Serial data from the nearest converter |
| conv_n | output | 1 | Shared convert line, active low |
| dclk | output | 1 | Gated data clock to all converters |
| word_valid | output | 1 | One-cycle strobe for a received word |
| word_idx | output | IW | Chain position of the reported word |
| word_data | output | DW | Received word after format selection |
| frame_done | output | 1 | Pulses with the last word of a frame |
| win_err | output | 1 | Last start was refused because the read would overrun the window |

## Verification
The bench drives the separator bits high in some frames. A framer that counted slots wrongly would shift that 1 into the next word, or would shift every later word by one bit. It runs the window check at one cycle below and exactly at the computed read length. An off-by-one comparison would either refuse a read that fits or start one that overruns. A start is pulsed in the middle of a shift, and a reset is applied in the middle of a shift. A controller that restarted would show a second convert pulse or extra clock edges. One that kept state through reset would leave the clock or valid high. Patterns at both extremes of full scale check the MSB re-coding, where an inverted polarity would swap the two extremes.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_SETUP,
    ST_SHIFT
  } rdo_state_e;
endpackage

// File: rtl/rdo_sync.sv
module rdo_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= {STAGES{RST_VAL}};
    else        sr_q <= {sr_q[STAGES-2:0], d};
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/rdo_clkgen.sv
module rdo_clkgen #(
  parameter int HALF_CYC = 2,
  parameter int NCLK     = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic dclk,
  output logic fall_now,
  output logic last_fall
);
  localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int CW = $clog2(NCLK + 1);

  logic [PW-1:0] ph_q, ph_d;
  logic          lvl_q, lvl_d;
  logic [CW-1:0] nf_q, nf_d;
  logic          edge_now;

  // phase boundary reached while running
  assign edge_now  = run && (ph_q == PW'(HALF_CYC - 1));
  assign fall_now  = edge_now && lvl_q;
  assign last_fall = fall_now && (nf_q == CW'(NCLK - 1));

  always_comb begin
    ph_d  = ph_q;
    lvl_d = lvl_q;
    nf_d  = nf_q;
    if (!run) begin
      ph_d  = '0;
      lvl_d = 1'b0;
      nf_d  = '0;
    end else if (edge_now) begin
      ph_d  = '0;
      lvl_d = ~lvl_q;
      if (lvl_q) nf_d = nf_q + CW'(1);
    end else begin
      ph_d = ph_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      lvl_q <= 1'b0;
      nf_q  <= '0;
    end else begin
      ph_q  <= ph_d;
      lvl_q <= lvl_d;
      nf_q  <= nf_d;
    end
  end

  assign dclk = lvl_q;
endmodule

// File: rtl/rdo_framer.sv
module rdo_framer #(
  parameter int DW    = 16,
  parameter int N_DEV = 3,
  parameter int IW    = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          smp,
  input  logic          sd,
  input  logic          offset_fmt,
  output logic          wvalid,
  output logic [IW-1:0] widx,
  output logic [DW-1:0] wdata
);
  localparam int SW = $clog2(DW + 1);

  logic [DW-1:0] sh_q, sh_d;
  logic [SW-1:0] pos_q, pos_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          wv_q, wv_d;
  logic [IW-1:0] wi_q, wi_d;
  logic [DW-1:0] wd_q, wd_d;
  logic [DW-1:0] word_w;

  assign word_w = {sh_q[DW-2:0], sd};

  always_comb begin
    sh_d  = sh_q;
    pos_d = pos_q;
    idx_d = idx_q;
    wv_d  = 1'b0;
    wi_d  = wi_q;
    wd_d  = wd_q;
    if (clr) begin
      pos_d = '0;
      idx_d = '0;
    end else if (smp) begin
      if (pos_q == SW'(DW)) begin
        // separator slot: bit is dropped
        pos_d = '0;
      end else begin
        sh_d  = word_w;
        pos_d = pos_q + SW'(1);
        if (pos_q == SW'(DW - 1)) begin
          wv_d  = 1'b1;
          wi_d  = idx_q;
          wd_d  = offset_fmt ? {~word_w[DW-1], word_w[DW-2:0]} : word_w;
          idx_d = idx_q + IW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      pos_q <= '0;
      idx_q <= '0;
      wv_q  <= 1'b0;
      wi_q  <= '0;
      wd_q  <= '0;
    end else begin
      sh_q  <= sh_d;
      pos_q <= pos_d;
      idx_q <= idx_d;
      wv_q  <= wv_d;
      wi_q  <= wi_d;
      wd_q  <= wd_d;
    end
  end

  assign wvalid = wv_q;
  assign widx   = wi_q;
  assign wdata  = wd_q;
endmodule

// File: rtl/chain_readout_ctrl.sv
module chain_readout_ctrl
  import rdo_pkg::*;
#(
  parameter int N_DEV     = 3,
  parameter int DW        = 16,
  parameter int HALF_CYC  = 2,
  parameter int CONV_CYC  = 5,
  parameter int SETUP_CYC = 3,
  parameter int WIN_W     = 16,
  parameter int IW        = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             offset_fmt,
  input  logic [WIN_W-1:0] acq_window,
  input  logic             busy_i,
  input  logic             sdata,
  output logic             conv_n,
  output logic             dclk,
  output logic             word_valid,
  output logic [IW-1:0]    word_idx,
  output logic [DW-1:0]    word_data,
  output logic             frame_done,
  output logic             win_err
);
  localparam int NCLK     = DW + (DW + 1) * (N_DEV - 1);
  localparam int READ_CYC = SETUP_CYC + 2 * HALF_CYC * NCLK;
  localparam int CNT_MAX  = (CONV_CYC > SETUP_CYC) ? CONV_CYC : SETUP_CYC;
  localparam int CTW      = $clog2(CNT_MAX + 1);

  rdo_state_e     st_q, st_d;
  logic [CTW-1:0] cnt_q, cnt_d;
  logic           err_q, err_d;
  logic           done_q, done_d;
  logic           conv_n_q;
  logic           clr;
  logic           run;
  logic           busy_s;
  logic           fall_now;
  logic           last_fall;
  logic           too_long;

  rdo_sync #(.STAGES(2), .RST_VAL(1'b1)) u_busy_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (busy_i),
    .q     (busy_s)
  );

  assign run      = (st_q == ST_SHIFT);
  assign too_long = (32'(acq_window) < 32'(READ_CYC));

  rdo_clkgen #(.HALF_CYC(HALF_CYC), .NCLK(NCLK)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .dclk      (dclk),
    .fall_now  (fall_now),
    .last_fall (last_fall)
  );

  rdo_framer #(.DW(DW), .N_DEV(N_DEV), .IW(IW)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .smp        (fall_now),
    .sd         (sdata),
    .offset_fmt (offset_fmt),
    .wvalid     (word_valid),
    .widx       (word_idx),
    .wdata      (word_data)
  );

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    err_d  = err_q;
    done_d = 1'b0;
    clr    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (too_long) begin
            err_d = 1'b1;
          end else begin
            err_d = 1'b0;
            st_d  = ST_CONV;
            cnt_d = '0;
            clr   = 1'b1;
          end
        end
      end
      ST_CONV: begin
        if (cnt_q == CTW'(CONV_CYC - 1)) st_d = ST_WAIT_LO;
        else                             cnt_d = cnt_q + CTW'(1);
      end
      ST_WAIT_LO: begin
        if (!busy_s) st_d = ST_WAIT_HI;
      end
      ST_WAIT_HI: begin
        if (busy_s) begin
          st_d  = ST_SETUP;
          cnt_d = '0;
        end
      end
      ST_SETUP: begin
        if (cnt_q == CTW'(SETUP_CYC - 1)) st_d = ST_SHIFT;
        else                              cnt_d = cnt_q + CTW'(1);
      end
      ST_SHIFT: begin
        if (last_fall) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      conv_n_q <= 1'b1;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      err_q    <= err_d;
      done_q   <= done_d;
      conv_n_q <= (st_d != ST_CONV);
    end
  end

  assign conv_n     = conv_n_q;
  assign frame_done = done_q;
  assign win_err    = err_q;
endmodule

// File: rtl/chain_readout_chk.sv
module chain_readout_chk #(
  parameter int N_DEV    = 3,
  parameter int HALF_CYC = 2,
  parameter int CONV_CYC = 5,
  parameter int IW       = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_i,
  input logic          conv_n,
  input logic          dclk,
  input logic          word_valid,
  input logic [IW-1:0] word_idx,
  input logic          frame_done,
  input logic          win_err
);
  logic [15:0] hi_cnt, lo_cnt, cv_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
      cv_cnt <= '0;
    end else begin
      hi_cnt <= dclk ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1) : 16'd0;
      lo_cnt <= !dclk ? ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 16'd1) : 16'd0;
      cv_cnt <= !conv_n ? ((cv_cnt == 16'hFFFF) ? cv_cnt : cv_cnt + 16'd1) : 16'd0;
    end
  end

  assert_conv_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_n) |-> (cv_cnt == 16'(CONV_CYC)));

  assert_quiet_convert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_n |-> !dclk);

  assert_quiet_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> !dclk);

  assert_high_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dclk) |-> (hi_cnt >= 16'(HALF_CYC)));

  assert_low_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk) |-> (lo_cnt >= 16'(HALF_CYC)));

  assert_single_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (word_idx <= IW'(N_DEV - 1)));

  assert_done_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (word_valid && (word_idx == IW'(N_DEV - 1))));

  assert_err_no_conv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_err |-> conv_n);
endmodule

bind chain_readout_ctrl chain_readout_chk #(
  .N_DEV(N_DEV), .HALF_CYC(HALF_CYC), .CONV_CYC(CONV_CYC), .IW(IW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_i     (busy_i),
  .conv_n     (conv_n),
  .dclk       (dclk),
  .word_valid (word_valid),
  .word_idx   (word_idx),
  .frame_done (frame_done),
  .win_err    (win_err)
);

// File: tb/chain_readout_ctrl_test.sv
`timescale 1ns/1ps
module chain_readout_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV  = 3;
  localparam int NCLK  = 16 + 17 * (NDEV - 1);
  localparam int RDCYC = 3 + 2 * 2 * NCLK;
  localparam int CONVC = 5;

  // {w0, w1, w2, separator level, offset_fmt, exp0, exp1, exp2}
  localparam logic [97:0] VECS [0:3] = '{
    {16'h7FFF, 16'h8000, 16'h0000, 1'b0, 1'b0, 16'h7FFF, 16'h8000, 16'h0000},
    {16'h7FFF, 16'h8000, 16'h0000, 1'b0, 1'b1, 16'hFFFF, 16'h0000, 16'h8000},
    {16'hA5A5, 16'h5A5A, 16'hFFFF, 1'b1, 1'b0, 16'hA5A5, 16'h5A5A, 16'hFFFF},
    {16'h0001, 16'hFFFE, 16'h1234, 1'b1, 1'b1, 16'h8001, 16'h7FFE, 16'h9234}
  };

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        offset_fmt;
  logic [15:0] acq_window;
  logic        busy_i = 1'b1;
  logic        sdata  = 1'b0;
  logic        conv_n;
  logic        dclk;
  logic        word_valid;
  logic [1:0]  word_idx;
  logic [15:0] word_data;
  logic        frame_done;
  logic        win_err;

  logic [49:0] stream;
  int kbase;
  int k = 0;
  int nbad = 0;
  int nconv = 0;
  int ndone = 0;
  int cap_n = 0;
  int lo_run = 0;
  int last_lo = 0;
  logic [15:0] cap_d [0:63];
  logic [1:0]  cap_i [0:63];
  int nchk = 0;
  int nfail = 0;

  chain_readout_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .offset_fmt(offset_fmt),
    .acq_window(acq_window), .busy_i(busy_i), .sdata(sdata),
    .conv_n(conv_n), .dclk(dclk), .word_valid(word_valid),
    .word_idx(word_idx), .word_data(word_data), .frame_done(frame_done),
    .win_err(win_err)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // converter chain model: busy low after the convert edge, then high
  always @(negedge conv_n) begin
    nconv = nconv + 1;
    #30  busy_i = 1'b0;
    #500 busy_i = 1'b1;
  end

  // each rising data clock edge presents the next stream bit
  always @(posedge dclk) begin
    if (k - kbase < 50) sdata <= stream[49 - (k - kbase)];
    k = k + 1;
    if (!busy_i || !conv_n) nbad = nbad + 1;
  end

  always @(negedge clk) begin
    if (word_valid) begin
      cap_d[cap_n & 63] = word_data;
      cap_i[cap_n & 63] = word_idx;
      cap_n = cap_n + 1;
    end
    if (frame_done) ndone = ndone + 1;
    if (!conv_n) lo_run = lo_run + 1;
    else if (lo_run != 0) begin
      last_lo = lo_run;
      lo_run  = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (ndone > d0) break;
    end
  endtask

  task automatic run_row(input int row, input int mid_start);
    logic [97:0] v;
    int kb, cb, capb, db;
    v = VECS[row];
    stream = {v[97:82], v[49], v[81:66], v[49], v[65:50]};
    offset_fmt = v[48];
    kbase = k;
    kb = k; cb = nconv; capb = cap_n; db = ndone;
    pulse_start();
    if (mid_start != 0) begin
      repeat (100) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    wait_done(db);
    chk("R7 frame_done seen", 32'(ndone - db), 32'd1);
    chk("R1 one convert pulse", 32'(nconv - cb), 32'd1);
    chk("R1 convert width", 32'(last_lo), 32'(CONVC));
    chk("R3 data clock count", 32'(k - kb), 32'(NCLK));
    chk("R2 no clock in conversion", 32'(nbad), 32'd0);
    chk("R7 word count", 32'(cap_n - capb), 32'd3);
    for (int w = 0; w < 3; w++) begin
      chk("R4 word index order", 32'(cap_i[(capb + w) & 63]), 32'(w));
      chk(v[49] ? "R5 R6 word value, separator high" : "R4 R6 word value",
          32'(cap_d[(capb + w) & 63]), 32'(v[47 - 16*w -: 16]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL R7 watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int c0, k0;
    kbase = 0;
    start = 1'b0;
    offset_fmt = 1'b0;
    acq_window = 16'd1000;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset conv_n", 32'(conv_n), 32'd1);
    chk("R10 reset dclk", 32'(dclk), 32'd0);
    chk("R10 reset word_valid", 32'(word_valid), 32'd0);
    chk("R10 reset win_err", 32'(win_err), 32'd0);
    chk("R10 reset frame_done", 32'(frame_done), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int r = 0; r < 4; r++) run_row(r, 0);

    // R9: second start in the middle of the shift is ignored
    run_row(2, 1);
    c0 = nconv;
    repeat (60) @(negedge clk);
    chk("R9 no extra conversion", 32'(nconv - c0), 32'd0);

    // R8: window one cycle short is refused
    acq_window = 16'(RDCYC - 1);
    c0 = nconv; k0 = k;
    pulse_start();
    repeat (100) @(negedge clk);
    chk("R8 win_err set", 32'(win_err), 32'd1);
    chk("R8 no conversion when refused", 32'(nconv - c0), 32'd0);
    chk("R8 no clocks when refused", 32'(k - k0), 32'd0);

    // R8: window equal to the read length is accepted
    acq_window = 16'(RDCYC);
    run_row(1, 0);
    chk("R8 win_err cleared", 32'(win_err), 32'd0);

    // R10: reset in the middle of a shift
    acq_window = 16'd1000;
    stream = '0;
    kbase = k;
    pulse_start();
    repeat (120) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mid reset dclk", 32'(dclk), 32'd0);
    chk("R10 mid reset conv_n", 32'(conv_n), 32'd1);
    chk("R10 mid reset word_valid", 32'(word_valid), 32'd0);
    k0 = k;
    repeat (20) @(negedge clk);
    chk("R10 no clocks in reset", 32'(k - k0), 32'd0);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    run_row(3, 0);

    summary();
    $finish;
  end
endmodule